// File: doc/BRIEF.md
# Flash Write Unlock Controller

This block guards program operations on nonvolatile memory. It sits on a small CPU register bus and has two addresses. One is an 8-bit control/status register. The other is a key port that stores nothing: only the pattern of writes made to it counts. A program cycle starts only when all of these hold:

- writes are enabled;
- the bus has just seen a two-write key pattern on the key port;
- the very next bus write sets the start bit.

While the cycle runs, the block does two things. It holds the CPU stalled, and it gives a memory model a one-cycle program strobe. The memory cell itself is a fixed-latency busy timer.

A normal finish clears the start bit and pulses a completion flag for one clock. A warm reset cuts the cycle short instead, and sets a sticky error bit. Warm resets come from an external master reset or a watchdog. The error bit survives the warm reset, so software can find the aborted write later and program it again. Only a power-on reset clears every bit.

Top module: `nvm_prog_guard`

## Requirements
- R1: After power-on reset (`por_n` low), the control register reads 0x00. `cpu_stall`, `prog_strobe` and `done_irq` are all low.
- R2: Control register layout, bit 7 down to bit 0: memory select, config select, reserved, free, write error, write enable, write start, read start. Software writes and reads back bits 7, 6, 4, 3 and 2. Bit 5 always reads 0. The key port (address 1) reads 0x00, and the control register is at address 0.
- R3: A cycle starts when a control write has bit 2 = 1 and bit 1 = 1, and the two bus writes just before it were 0x55 and then 0xAA to the key port. `cpu_stall` and the start bit then read 1 from the next cycle, for exactly PROG_CYCLES cycles.
- R4: Any other bus write in between leaves the start write with no effect. This covers a control write, a wrong key byte, or the two bytes in the wrong order. After such a write, the start bit reads 0 and `cpu_stall` stays low.
- R5: A start write whose bit 2 (write enable) is 0 starts no cycle, even after a valid key.
- R6: `prog_strobe` is high for exactly one cycle: the first busy cycle.
- R7: `done_irq` is high for exactly one cycle after a normal finish. That cycle is the first one in which `cpu_stall` is low again. In that cycle the start bit reads 0.
- R8: Bus writes made while a cycle is busy are ignored. Software cannot clear the start bit, and the register contents do not change.
- R9: A warm reset (`wrst_n` low) keeps bits 7, 6 and 3, and clears bits 4, 2, 1 and 0. If it arrives while a cycle is busy, it also ends the stall, sets bit 3, and gives no `done_irq`.
- R10: Writing 1 to read start (bit 0) makes the bit read 1 for one cycle only.
- R11: A key unlocks one start write only. A second start write without a fresh key does nothing.
- R12: Software can clear the write-error bit by writing 0 to bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| wrst_n | input | 1 | Warm reset (master or watchdog), synchronous, active low |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| cpu_stall | output | 1 | Holds the CPU while a cycle is busy |
| prog_strobe | output | 1 | One-cycle program command to the memory model |
| done_irq | output | 1 | One-cycle completion flag |

## Verification
The hardest state to reach is an aborted program cycle. Two things must happen in order: a fully unlocked start, and then a warm reset that lands strictly inside the busy window. The bench reaches it with a valid key and a start write that also sets both select bits. It then drops `wrst_n` for one cycle partway through the busy window. After that it reads back the select bits, the new error bit, the cleared enable bit and a silent completion flag. Near-miss key orders come from a vector table that puts a write in each slot of the pattern.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
   localparam int REG_W  = 8;
   localparam int B_MEM  = 7;
   localparam int B_CFG  = 6;
   localparam int B_RSV  = 5;
   localparam int B_FREE = 4;
   localparam int B_WERR = 3;
   localparam int B_WEN  = 2;
   localparam int B_WR   = 1;
   localparam int B_RD   = 0;

   typedef enum logic [1:0] {
      K_IDLE  = 2'd0,
      K_HALF  = 2'd1,
      K_ARMED = 2'd2
   } key_st_t;
endpackage

// File: rtl/nvm_key_fsm.sv
module nvm_key_fsm
   import nvm_guard_pkg::*;
#(
   parameter logic [REG_W-1:0] KEY_A = 8'h55,
   parameter logic [REG_W-1:0] KEY_B = 8'hAA
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             wrst_n,
   input  logic             any_we,
   input  logic             key_we,
   input  logic [REG_W-1:0] wdata,
   output logic             armed
);
   key_st_t st_q;

   // Only back-to-back key writes advance; any other write drops to idle.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         st_q <= K_IDLE;
      else if (!wrst_n)
         st_q <= K_IDLE;
      else if (key_we) begin
         if (st_q == K_HALF && wdata == KEY_B)
            st_q <= K_ARMED;
         else if (wdata == KEY_A)
            st_q <= K_HALF;
         else
            st_q <= K_IDLE;
      end else if (any_we)
         st_q <= K_IDLE;
   end

   assign armed = (st_q == K_ARMED);
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic wrst_n,
   input  logic start,
   output logic busy,
   output logic strobe,
   output logic done
);
   logic strobe_q;
   logic done_q;

   generate
      if (CYCLES == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               busy_q <= 1'b0;
               done_q <= 1'b0;
            end else if (!wrst_n) begin
               busy_q <= 1'b0;
               done_q <= 1'b0;
            end else begin
               busy_q <= start;
               done_q <= busy_q;
            end
         end
         assign busy = busy_q;
      end else begin : g_count
         localparam int CNT_W = $clog2(CYCLES + 1);
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);
         localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else if (!wrst_n) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else begin
               done_q <= (cnt_q == ONE);
               if (start)
                  cnt_q <= LOAD;
               else if (cnt_q != '0)
                  cnt_q <= cnt_q - ONE;
            end
         end
         assign busy = (cnt_q != '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         strobe_q <= 1'b0;
      else if (!wrst_n)
         strobe_q <= 1'b0;
      else
         strobe_q <= start;
   end

   assign strobe = strobe_q;
   assign done   = done_q;
endmodule

// File: rtl/nvm_ctrl_reg.sv
module nvm_ctrl_reg
   import nvm_guard_pkg::*;
(
   input  logic             clk,
   input  logic             por_n,
   input  logic             wrst_n,
   input  logic             ctrl_we,
   input  logic [REG_W-1:0] wdata,
   input  logic             busy,
   output logic             mem_sel,
   output logic             cfg_sel,
   output logic             free_q,
   output logic             werr_q,
   output logic             wen_q,
   output logic             rd_q
);
   logic unused_bits;
   assign unused_bits = wdata[B_RSV] ^ wdata[B_WR];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mem_sel <= 1'b0;
         cfg_sel <= 1'b0;
         free_q  <= 1'b0;
         werr_q  <= 1'b0;
         wen_q   <= 1'b0;
         rd_q    <= 1'b0;
      end else if (!wrst_n) begin
         // selects persist; an in-flight cycle marks the error flag
         werr_q <= werr_q | busy;
         free_q <= 1'b0;
         wen_q  <= 1'b0;
         rd_q   <= 1'b0;
      end else if (ctrl_we) begin
         mem_sel <= wdata[B_MEM];
         cfg_sel <= wdata[B_CFG];
         free_q  <= wdata[B_FREE];
         werr_q  <= wdata[B_WERR];
         wen_q   <= wdata[B_WEN];
         rd_q    <= wdata[B_RD];
      end else begin
         rd_q <= 1'b0;
      end
   end
endmodule

// File: rtl/nvm_prog_guard.sv
module nvm_prog_guard
   import nvm_guard_pkg::*;
#(
   parameter int               PROG_CYCLES = 16,
   parameter int               ADDR_W      = 1,
   parameter int               CTRL_ADDR   = 0,
   parameter int               KEY_ADDR    = 1,
   parameter logic [REG_W-1:0] KEY_A       = 8'h55,
   parameter logic [REG_W-1:0] KEY_B       = 8'hAA
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wrst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              cpu_stall,
   output logic              prog_strobe,
   output logic              done_irq
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_ADDR);

   generate
      if (PROG_CYCLES < 1) begin : g_bad_cycles
         $error("PROG_CYCLES must be at least 1");
      end
      if (CTRL_ADDR == KEY_ADDR) begin : g_bad_map
         $error("control and key addresses must differ");
      end
      if (CTRL_ADDR >= (1 << ADDR_W) || KEY_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("register address does not fit ADDR_W");
      end
      if (KEY_A == KEY_B) begin : g_bad_key
         $error("the two key bytes must differ");
      end
   endgenerate

   logic busy_w, armed_w, start_w;
   logic we_ok, key_we, ctrl_we;
   logic mem_w, cfg_w, free_w, werr_w, wen_w, rd_w;

   assign we_ok   = bus_we & ~busy_w;
   assign key_we  = we_ok & (bus_addr == A_KEY);
   assign ctrl_we = we_ok & (bus_addr == A_CTRL);
   assign start_w = ctrl_we & armed_w & bus_wdata[B_WR] & bus_wdata[B_WEN];

   nvm_key_fsm #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
      .clk(clk), .por_n(por_n), .wrst_n(wrst_n),
      .any_we(we_ok), .key_we(key_we), .wdata(bus_wdata),
      .armed(armed_w)
   );

   nvm_busy_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
      .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .start(start_w),
      .busy(busy_w), .strobe(prog_strobe), .done(done_irq)
   );

   nvm_ctrl_reg u_reg (
      .clk(clk), .por_n(por_n), .wrst_n(wrst_n),
      .ctrl_we(ctrl_we), .wdata(bus_wdata), .busy(busy_w),
      .mem_sel(mem_w), .cfg_sel(cfg_w), .free_q(free_w),
      .werr_q(werr_w), .wen_q(wen_w), .rd_q(rd_w)
   );

   always_comb begin
      if (bus_addr == A_CTRL)
         bus_rdata = {mem_w, cfg_w, 1'b0, free_w, werr_w, wen_w, busy_w, rd_w};
      else
         bus_rdata = '0;
   end

   assign cpu_stall = busy_w;
endmodule

// File: rtl/nvm_prog_guard_chk.sv
module nvm_prog_guard_chk #(
   parameter int PROG_CYCLES = 16,
   parameter int ADDR_W      = 1,
   parameter int CTRL_ADDR   = 0
) (
   input logic              clk,
   input logic              por_n,
   input logic              wrst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              cpu_stall,
   input logic              prog_strobe,
   input logic              done_irq,
   input logic              werr_w
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   int unsigned run_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         run_q <= 0;
      else if (cpu_stall)
         run_q <= run_q + 1;
      else
         run_q <= 0;
   end

   p_stall_len_r3: assert property (@(posedge clk) disable iff (!por_n)
      cpu_stall |-> (run_q < PROG_CYCLES));

   p_start_needs_wen_r5: assert property (@(posedge clk) disable iff (!por_n)
      $rose(cpu_stall) |-> $past(bus_we && bus_addr == A_CTRL && bus_wdata[2] && bus_wdata[1]));

   p_strobe_first_r6: assert property (@(posedge clk) disable iff (!por_n)
      prog_strobe |-> (cpu_stall && run_q == 0));

   p_irq_after_busy_r7: assert property (@(posedge clk) disable iff (!por_n)
      done_irq |-> (!cpu_stall && $past(cpu_stall)));

   p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!por_n)
      done_irq |=> !done_irq);

   p_start_bit_held_r8: assert property (@(posedge clk) disable iff (!por_n)
      (cpu_stall && bus_addr == A_CTRL) |-> bus_rdata[1]);

   p_werr_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
      (cpu_stall && wrst_n) |=> $stable(werr_w));

   p_abort_err_r9: assert property (@(posedge clk) disable iff (!por_n)
      (cpu_stall && !wrst_n) |=> (werr_w && !cpu_stall && !done_irq));

   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
      (bus_addr == A_CTRL) |-> !bus_rdata[5]);
endmodule

bind nvm_prog_guard nvm_prog_guard_chk #(
   .PROG_CYCLES(PROG_CYCLES), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
   .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .cpu_stall(cpu_stall), .prog_strobe(prog_strobe), .done_irq(done_irq),
   .werr_w(werr_w)
);

// File: tb/sim_nvm_prog_guard.sv
`timescale 1ns/1ps
module sim_nvm_prog_guard;
   localparam int PC = 6;
   localparam logic C = 1'b0;
   localparam logic K = 1'b1;

   // row: {a0,d0, a1,d1, a2,d2, a3,d3, start_expected}
   localparam logic [36:0] VEC [8] = '{
      {C,8'h04, K,8'h55, K,8'hAA, C,8'h06, 1'b1},  // R3 clean unlock
      {K,8'h55, K,8'hAA, C,8'h04, C,8'h06, 1'b0},  // R4 control write between
      {K,8'h55, K,8'h55, K,8'hAA, C,8'h06, 1'b1},  // R3 repeated first byte
      {K,8'h55, K,8'hAB, K,8'hAA, C,8'h06, 1'b0},  // R4 wrong byte
      {C,8'h04, K,8'h55, K,8'hAA, C,8'h02, 1'b0},  // R5 enable clear
      {K,8'hAA, K,8'h55, K,8'hAA, C,8'h06, 1'b1},  // R3 stray byte first
      {K,8'h55, K,8'hAA, K,8'h00, C,8'h06, 1'b0},  // R4 extra key write
      {C,8'h00, K,8'hAA, K,8'h55, C,8'h06, 1'b0}   // R4 reversed order
   };

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       wrst_n = 1'b1;
   logic       bus_we = 1'b0;
   logic [0:0] bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       cpu_stall, prog_strobe, done_irq;
   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   nvm_prog_guard #(.PROG_CYCLES(PC)) u0 (
      .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_stall(cpu_stall), .prog_strobe(prog_strobe), .done_irq(done_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      while (cpu_stall) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog act=%0d exp=done", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      repeat (3) @(negedge clk);
      // reset state
      rd(C, v); chk("R1 ctrl", v, 8'h00);
      chk("R1 stall", cpu_stall, 0);
      chk("R1 strobe", prog_strobe, 0);
      chk("R1 irq", done_irq, 0);
      por_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 4; j++)
            wr(VEC[i][36-9*j], VEC[i][35-9*j -: 8]);
         if (VEC[i][0]) begin
            chk($sformatf("R3 row%0d stall", i), cpu_stall, 1);
            chk("R6 strobe first", prog_strobe, 1);
            rd(C, v); chk("R3 start bit busy", v[1], 1);
            n = 1;
            @(negedge clk);
            chk("R6 strobe single", prog_strobe, 0);
            while (cpu_stall) begin n++; @(negedge clk); end
            chk("R3 busy length", n, PC);
            chk("R7 irq at end", done_irq, 1);
            rd(C, v); chk("R7 start bit clear", v[1], 0);
            @(negedge clk);
            chk("R7 irq single", done_irq, 0);
         end else begin
            chk($sformatf("R4 row%0d stall", i), cpu_stall, 0);
            rd(C, v); chk("R4 start bit", v[1], 0);
            @(negedge clk);
            chk("R4 irq", done_irq, 0);
         end
      end

      // R11: no fresh key
      wr(C, 8'h06);
      chk("R11 reuse stall", cpu_stall, 0);

      // R2 / R10: plain control write, key reads zero
      wr(C, 8'hFF);
      rd(C, v); chk("R2 R10 ctrl map", v, 8'hDD);
      @(negedge clk);
      rd(C, v); chk("R10 read-start clears", v, 8'hDC);
      rd(K, v); chk("R2 key reads zero", v, 8'h00);

      // R12: software clears the error bit
      wr(C, 8'hD4);
      rd(C, v); chk("R12 werr cleared", v, 8'hD4);

      // R8: writes during busy ignored
      wr(K, 8'h55); wr(K, 8'hAA); wr(C, 8'h06);
      chk("R8 started", cpu_stall, 1);
      wr(C, 8'hF8);
      rd(C, v); chk("R8 ctrl unchanged", v, 8'h06);
      chk("R8 still busy", cpu_stall, 1);
      wait_idle();
      @(negedge clk);

      // R9: warm reset mid-cycle
      wr(K, 8'h55); wr(K, 8'hAA); wr(C, 8'hD6);
      @(negedge clk);
      chk("R9 busy before abort", cpu_stall, 1);
      wrst_n = 1'b0;
      @(negedge clk);
      wrst_n = 1'b1;
      chk("R9 stall dropped", cpu_stall, 0);
      chk("R9 no irq", done_irq, 0);
      rd(C, v); chk("R9 ctrl after abort", v, 8'hC8);
      @(negedge clk);
      chk("R9 no late irq", done_irq, 0);

      // R9: warm reset while idle leaves error clear
      wr(C, 8'hD4);
      wrst_n = 1'b0;
      @(negedge clk);
      wrst_n = 1'b1;
      rd(C, v); chk("R9 idle warm reset", v, 8'hC0);

      // R1: power-on reset clears selects
      por_n = 1'b0;
      #1;
      rd(C, v); chk("R1 por clears", v, 8'h00);
      @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule